// File: doc/BRIEF.md
# Warp Issue and Latency Simulator

This block is a cycle-stepped performance model of one streaming multiprocessor that runs a group of warps. Each warp carries three instruction budgets: arithmetic, shared-memory access and global-memory access. On every step, each warp that has finished its previous instruction draws its next instruction type at random from the budgets that are still nonzero. Warps holding a selected instruction compete for a small pool of scheduler slots. The slots are granted in a random order that changes every step.

Shared-memory accesses keep their slot until their fixed latency has elapsed. Global-memory accesses give their slot back as soon as they issue, so other warps can run while the access waits. The block counts the total number of steps until every active warp has terminated. It also counts the idle steps, in which no warp had an instruction ready to issue.

A start pulse loads the budgets, the active-warp mask, the scheduler choice, the latencies and the random seed. When the run ends, done rises and holds the results until the next start pulse. The same seed with the same configuration reproduces a run exactly.

Top module: `warp_issue_sim`

## Requirements
- R1: After reset, done is 0 and both step counts are 0.
- R2: An arithmetic instruction takes one selection step and one issue step. A warp also spends one final step on termination once all its budgets are zero. A single active warp with `a` arithmetic instructions and no other budget therefore ends with total = 2a+1 and idle = a+1.
- R3: A shared access holds its slot during its issue step and for `slat` wait steps after it. A single warp with `s` shared accesses ends with total = s(2+slat)+1 and idle = s(1+slat)+1.
- R4: A global access waits `glat` steps after issue. A single warp with `g` global accesses ends with total = g(2+glat)+1 and idle = g(1+glat)+1.
- R5: The slot pool holds 2 slots when sched_sel is 0 and 4 when it is 1. Within a step, the issued instructions plus the shared accesses still holding a slot never exceed the pool. Four warps with 3 arithmetic instructions each end with total 8 and idle 2 on 2 slots, and with total 7 and idle 4 on 4 slots.
- R6: A global access returns its slot at issue, while a shared access returns it on completion. Four warps with one access each on 2 slots at latency 10 end with total 14 for global and total 24 for shared, and idle 12 in both cases.
- R7: The instruction type is drawn only from the nonzero budgets, and each draw consumes one unit of that budget. A single warp with one instruction of each type, slat 2 and glat 3 ends with total 12 and idle 9 in every draw order.
- R8: Warp i takes its budgets from bits [i*BUD_W +: BUD_W] of each budget bus and takes part only when warp_en[i] is 1. An inactive warp has no effect on the counts. With no warp active, done rises with both counts 0. An active warp whose budgets are all zero gives total 1 and idle 1.
- R9: The idle count grows only on steps in which no warp has a selected instruction waiting for a slot. It never exceeds the total.
- R10: Two runs with the same seed and configuration give identical counts.
- R11: Both counts saturate at their all-ones value.
- R12: done and both counts hold their values until the next start. The step after start shows done 0 and both counts 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads the configuration and begins a run |
| seed | input | 32 | Seed for the random source, loaded at start (zero is replaced by 1) |
| warp_en | input | NUM_WARPS | Active-warp mask |
| sched_sel | input | 1 | Slot pool size: 0 gives 2 slots, 1 gives 4 slots |
| glat | input | LAT_W | Global-access wait steps |
| slat | input | LAT_W | Shared-access wait steps |
| arith_bud | input | NUM_WARPS*BUD_W | Arithmetic budgets, one field per warp |
| shr_bud | input | NUM_WARPS*BUD_W | Shared-access budgets, one field per warp |
| glb_bud | input | NUM_WARPS*BUD_W | Global-access budgets, one field per warp |
| total_steps | output | STEP_W | Steps counted in the run |
| idle_steps | output | STEP_W | Steps with no ready warp |
| done | output | 1 | High from the end of a run until the next start |

## Verification
The assertions assume that start is a single-cycle pulse and that the configuration inputs stay constant while a run is in progress. They also assume that sched_sel selects one of the two legal pool sizes. The bench changes inputs only at the falling edge, and only before a start pulse or after done has risen. It picks budgets for which the step counts do not depend on the random draws, so every expected count follows from the requirement formulas. The one exception is the reproducibility case, which compares two runs with each other.

// File: rtl/wis_pkg.sv
package wis_pkg;

    typedef enum logic [1:0] {
        K_ARITH  = 2'd0,
        K_SHARED = 2'd1,
        K_GLOBAL = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        W_OFF = 3'd0,
        W_SEL = 3'd1,
        W_RDY = 3'd2,
        W_WSH = 3'd3,
        W_WGL = 3'd4
    } wstate_e;

    localparam int RND_W = 32;
    localparam logic [RND_W-1:0] RND_TAPS = 32'hA300_0001;

    // choose among the set bits of nz (bit0 arith, bit1 shared, bit2 global)
    function automatic kind_e pick_kind(input logic [2:0] nz, input logic [1:0] r);
        int n;
        int k;
        int seen;
        kind_e res;
        n = 0;
        for (int b = 0; b < 3; b++) n += int'(nz[b]);
        k = (n == 0) ? 0 : int'(r) % n;
        seen = 0;
        res = K_ARITH;
        for (int b = 0; b < 3; b++) begin
            if (nz[b]) begin
                if (seen == k) res = kind_e'(b);
                seen++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/wis_lfsr.sv
module wis_lfsr
    import wis_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RND_W-1:0] seed,
    input  logic             adv,
    output logic [RND_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RND_W'(1);
        end else if (load) begin
            q <= (seed == '0) ? RND_W'(1) : seed;
        end else if (adv) begin
            q <= q[0] ? ((q >> 1) ^ RND_TAPS) : (q >> 1);
        end
    end
endmodule

// File: rtl/wis_warp.sv
module wis_warp
    import wis_pkg::*;
#(
    parameter int BUD_W = 8,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             act,
    input  logic             step_en,
    input  logic [BUD_W-1:0] a_in,
    input  logic [BUD_W-1:0] s_in,
    input  logic [BUD_W-1:0] g_in,
    input  logic [LAT_W-1:0] glat,
    input  logic [LAT_W-1:0] slat,
    input  logic [1:0]       rnd,
    input  logic             grant,
    output logic             ready,
    output logic             hold,
    output logic             alive
);
    wstate_e          st;
    kind_e            kind;
    logic [BUD_W-1:0] ca, cs, cg;
    logic [LAT_W-1:0] wcnt;
    logic [2:0]       nz;
    kind_e            nxt;

    assign nz    = {cg != '0, cs != '0, ca != '0};
    assign nxt   = pick_kind(nz, rnd);
    assign ready = (st == W_RDY);
    assign hold  = (st == W_WSH);
    assign alive = (st != W_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= W_OFF;
            kind <= K_ARITH;
            ca   <= '0;
            cs   <= '0;
            cg   <= '0;
            wcnt <= '0;
        end else if (start) begin
            st   <= act ? W_SEL : W_OFF;
            kind <= K_ARITH;
            ca   <= a_in;
            cs   <= s_in;
            cg   <= g_in;
            wcnt <= '0;
        end else if (step_en) begin
            case (st)
                W_SEL: begin
                    if (nz == 3'b000) begin
                        st <= W_OFF;
                    end else begin
                        kind <= nxt;
                        st   <= W_RDY;
                        case (nxt)
                            K_ARITH:  ca <= ca - 1'b1;
                            K_SHARED: cs <= cs - 1'b1;
                            default:  cg <= cg - 1'b1;
                        endcase
                    end
                end
                W_RDY: begin
                    if (grant) begin
                        case (kind)
                            K_ARITH: st <= W_SEL;
                            K_SHARED: begin
                                wcnt <= slat;
                                st   <= (slat == '0) ? W_SEL : W_WSH;
                            end
                            default: begin
                                wcnt <= glat;
                                st   <= (glat == '0) ? W_SEL : W_WGL;
                            end
                        endcase
                    end
                end
                W_WSH, W_WGL: begin
                    if (wcnt == LAT_W'(1)) st <= W_SEL;
                    wcnt <= wcnt - 1'b1;
                end
                default: st <= W_OFF;
            endcase
        end
    end
endmodule

// File: rtl/wis_arb.sv
module wis_arb #(
    parameter int NW     = 8,
    parameter int SLOT_W = 3,
    localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [NW-1:0]     ready,
    input  logic [SLOT_W-1:0] avail,
    input  logic [IDX_W-1:0]  off,
    output logic [NW-1:0]     grant
);
    // rotating priority from a random start position
    always_comb begin
        int given;
        int idx;
        given = 0;
        grant = '0;
        for (int k = 0; k < NW; k++) begin
            idx = (int'(off) + k) % NW;
            if (ready[idx] && (given < int'(avail))) begin
                grant[idx] = 1'b1;
                given++;
            end
        end
    end
endmodule

// File: rtl/warp_issue_sim.sv
module warp_issue_sim
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int BUD_W     = 8,
    parameter int LAT_W     = 8,
    parameter int STEP_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [31:0]                seed,
    input  logic [NUM_WARPS-1:0]       warp_en,
    input  logic                       sched_sel,
    input  logic [LAT_W-1:0]           glat,
    input  logic [LAT_W-1:0]           slat,
    input  logic [NUM_WARPS*BUD_W-1:0] arith_bud,
    input  logic [NUM_WARPS*BUD_W-1:0] shr_bud,
    input  logic [NUM_WARPS*BUD_W-1:0] glb_bud,
    output logic [STEP_W-1:0]          total_steps,
    output logic [STEP_W-1:0]          idle_steps,
    output logic                       done
);
    localparam int SLOT_W = 3;
    localparam int IDX_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1;
    localparam logic [STEP_W-1:0] CNT_MAX = {STEP_W{1'b1}};

    logic                 run;
    logic                 step_en;
    logic [RND_W-1:0]     rnd;
    logic [NUM_WARPS-1:0] ready, hold, alive, grant;
    logic [SLOT_W-1:0]    slots, hold_cnt, avail;
    logic [IDX_W-1:0]     off;

    assign step_en = run && !start;
    assign slots   = sched_sel ? SLOT_W'(4) : SLOT_W'(2);
    assign off     = IDX_W'(rnd[31:16] % 16'(NUM_WARPS));

    always_comb begin
        hold_cnt = '0;
        for (int i = 0; i < NUM_WARPS; i++) hold_cnt = hold_cnt + SLOT_W'(hold[i]);
        avail = (hold_cnt >= slots) ? '0 : (slots - hold_cnt);
    end

    wis_lfsr u_rng (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .seed (seed),
        .adv  (step_en),
        .q    (rnd)
    );

    wis_arb #(.NW(NUM_WARPS), .SLOT_W(SLOT_W)) u_arb (
        .ready (ready),
        .avail (avail),
        .off   (off),
        .grant (grant)
    );

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_warp
        wis_warp #(.BUD_W(BUD_W), .LAT_W(LAT_W)) u_warp (
            .clk     (clk),
            .rst     (rst),
            .start   (start),
            .act     (warp_en[i]),
            .step_en (step_en),
            .a_in    (arith_bud[i*BUD_W +: BUD_W]),
            .s_in    (shr_bud[i*BUD_W +: BUD_W]),
            .g_in    (glb_bud[i*BUD_W +: BUD_W]),
            .glat    (glat),
            .slat    (slat),
            .rnd     ({rnd[(2*i+1) % RND_W], rnd[(2*i) % RND_W]}),
            .grant   (grant[i]),
            .ready   (ready[i]),
            .hold    (hold[i]),
            .alive   (alive[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run         <= 1'b0;
            done        <= 1'b0;
            total_steps <= '0;
            idle_steps  <= '0;
        end else if (start) begin
            run         <= 1'b1;
            done        <= 1'b0;
            total_steps <= '0;
            idle_steps  <= '0;
        end else if (run) begin
            if (alive != '0) begin
                if (total_steps != CNT_MAX) total_steps <= total_steps + 1'b1;
                if ((ready == '0) && (idle_steps != CNT_MAX)) idle_steps <= idle_steps + 1'b1;
            end else begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/warp_issue_sim_chk.sv
module warp_issue_sim_chk #(
    parameter int NW     = 8,
    parameter int STEP_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              run,
    input logic              sched_sel,
    input logic [NW-1:0]     grant,
    input logic [NW-1:0]     ready,
    input logic [NW-1:0]     hold,
    input logic [STEP_W-1:0] total_steps,
    input logic [STEP_W-1:0] idle_steps
);
    p_slot_limit_r5: assert property (@(posedge clk) disable iff (rst)
        ($countones(grant) + $countones(hold)) <= (sched_sel ? 4 : 2));

    p_grant_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (grant & ~ready) == '0);

    p_idle_bound_r9: assert property (@(posedge clk) disable iff (rst)
        idle_steps <= total_steps);

    p_done_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(total_steps) && $stable(idle_steps)));

    p_start_clear_r12: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && total_steps == '0 && idle_steps == '0));

    p_saturate_r11: assert property (@(posedge clk) disable iff (rst)
        (run && !start && total_steps == {STEP_W{1'b1}}) |=> (total_steps == {STEP_W{1'b1}}));
endmodule

bind warp_issue_sim warp_issue_sim_chk #(.NW(NUM_WARPS), .STEP_W(STEP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .done        (done),
    .run         (run),
    .sched_sel   (sched_sel),
    .grant       (grant),
    .ready       (ready),
    .hold        (hold),
    .total_steps (total_steps),
    .idle_steps  (idle_steps)
);

// File: tb/warp_issue_sim_test.sv
module warp_issue_sim_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int BW = 4;
    localparam int LW = 5;
    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [31:0]   seed;
    logic [NW-1:0] warp_en;
    logic          sched_sel;
    logic [LW-1:0] glat, slat;
    logic [NW*BW-1:0] arith_bud, shr_bud, glb_bud;
    logic [SW-1:0] total_steps, idle_steps;
    logic          done;

    int checks = 0;
    int errs   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_issue_sim #(.NUM_WARPS(NW), .BUD_W(BW), .LAT_W(LW), .STEP_W(SW)) uut (
        .clk(clk), .rst(rst), .start(start), .seed(seed), .warp_en(warp_en),
        .sched_sel(sched_sel), .glat(glat), .slat(slat), .arith_bud(arith_bud),
        .shr_bud(shr_bud), .glb_bud(glb_bud), .total_steps(total_steps),
        .idle_steps(idle_steps), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input logic [NW-1:0] en, input logic sel,
                            input logic [NW*BW-1:0] a, input logic [NW*BW-1:0] s,
                            input logic [NW*BW-1:0] g, input int gl, input int sl,
                            input logic [31:0] sd);
        int n;
        @(negedge clk);
        warp_en = en; sched_sel = sel; arith_bud = a; shr_bud = s; glb_bud = g;
        glat = LW'(gl); slat = LW'(sl); seed = sd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("run completes (done)", int'(done), 1);
    endtask

    task automatic t_reset;
        check("R1 done after reset", int'(done), 0);
        check("R1 total after reset", int'(total_steps), 0);
        check("R1 idle after reset", int'(idle_steps), 0);
    endtask

    task automatic t_arith;
        run_case(4'b0001, 1'b0, 16'h0005, 16'h0, 16'h0, 0, 0, 32'h1234);
        check("R2 total arith", int'(total_steps), 11);
        check("R2 R9 idle arith", int'(idle_steps), 6);
    endtask

    task automatic t_shared;
        run_case(4'b0001, 1'b0, 16'h0, 16'h0002, 16'h0, 0, 3, 32'h55);
        check("R3 total shared", int'(total_steps), 11);
        check("R3 R9 idle shared", int'(idle_steps), 9);
    endtask

    task automatic t_global;
        run_case(4'b0001, 1'b1, 16'h0, 16'h0, 16'h0002, 4, 0, 32'h77);
        check("R4 total global", int'(total_steps), 13);
        check("R4 R9 idle global", int'(idle_steps), 11);
    endtask

    task automatic t_slots;
        run_case(4'b1111, 1'b0, 16'h3333, 16'h0, 16'h0, 0, 0, 32'hABCD);
        check("R5 total 2 slots", int'(total_steps), 8);
        check("R5 idle 2 slots", int'(idle_steps), 2);
        run_case(4'b1111, 1'b1, 16'h3333, 16'h0, 16'h0, 0, 0, 32'hABCD);
        check("R5 total 4 slots", int'(total_steps), 7);
        check("R5 idle 4 slots", int'(idle_steps), 4);
    endtask

    task automatic t_hiding;
        run_case(4'b1111, 1'b0, 16'h0, 16'h0, 16'h1111, 10, 0, 32'h9);
        check("R6 total global release at issue", int'(total_steps), 14);
        check("R6 idle global", int'(idle_steps), 12);
        run_case(4'b1111, 1'b0, 16'h0, 16'h1111, 16'h0, 0, 10, 32'h9);
        check("R6 total shared release at end", int'(total_steps), 24);
        check("R6 idle shared", int'(idle_steps), 12);
    endtask

    task automatic t_mixed;
        for (int k = 0; k < 3; k++) begin
            run_case(4'b0001, 1'b0, 16'h0001, 16'h0001, 16'h0001, 3, 2, 32'h100 + 32'(k * 977));
            check("R7 total mixed", int'(total_steps), 12);
            check("R7 idle mixed", int'(idle_steps), 9);
        end
    endtask

    task automatic t_mask;
        run_case(4'b0001, 1'b0, 16'hFFF5, 16'hFFF0, 16'hFFF0, 5, 5, 32'h3);
        check("R8 inactive warps ignored total", int'(total_steps), 11);
        check("R8 inactive warps ignored idle", int'(idle_steps), 6);
        run_case(4'b0000, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 5, 5, 32'h3);
        check("R8 empty mask total", int'(total_steps), 0);
        check("R8 empty mask idle", int'(idle_steps), 0);
        run_case(4'b0100, 1'b0, 16'h0, 16'h0, 16'h0, 5, 5, 32'h3);
        check("R8 zero budget total", int'(total_steps), 1);
        check("R8 zero budget idle", int'(idle_steps), 1);
    endtask

    task automatic t_repeat;
        int t1, i1;
        run_case(4'b1111, 1'b0, 16'h1232, 16'h2101, 16'h0112, 3, 2, 32'hC0FFEE);
        t1 = int'(total_steps); i1 = int'(idle_steps);
        run_case(4'b1111, 1'b0, 16'h1232, 16'h2101, 16'h0112, 3, 2, 32'hC0FFEE);
        check("R10 same seed total", int'(total_steps), t1);
        check("R10 same seed idle", int'(idle_steps), i1);
    endtask

    task automatic t_saturate;
        run_case(4'b0001, 1'b0, 16'h0, 16'h0, 16'h0003, 20, 0, 32'h5);
        check("R11 total saturates", int'(total_steps), 63);
        check("R11 idle saturates", int'(idle_steps), 63);
    endtask

    task automatic t_hold;
        int t0;
        run_case(4'b0001, 1'b0, 16'h0002, 16'h0, 16'h0, 0, 0, 32'h8);
        t0 = int'(total_steps);
        repeat (6) @(negedge clk);
        check("R12 done held", int'(done), 1);
        check("R12 total held", int'(total_steps), t0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R12 done cleared by start", int'(done), 0);
        check("R12 total cleared by start", int'(total_steps), 0);
        while (!done) @(negedge clk);
        check("R12 rerun total", int'(total_steps), 5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; seed = '0; warp_en = '0; sched_sel = 1'b0;
        glat = '0; slat = '0; arith_bud = '0; shr_bud = '0; glb_bud = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_arith();
        t_shared();
        t_global();
        t_slots();
        t_hiding();
        t_mixed();
        t_mask();
        t_repeat();
        t_saturate();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule